// File: doc/BRIEF.md
# Two-Zeros-in-Three Serial Pattern Detector

This block watches a serial bit stream that arrives one bit per clock and raises a flag whenever the bit on the input now, together with the two bits accepted before it, holds exactly two zeros and one one. It is a Mealy machine. The flag is decoded from the stored state and the live input bit, so a match is reported in the same cycle as the bit that completes it. The state register then takes that bit on the next rising edge.

After reset the machine passes through start-up states that record how many bits it has seen. No match can be reported until two bits have been accepted, so the window is never judged on history from before the reset. After that, one of four steady states holds the two most recent bits, and every new bit shifts into that history. A synchronous reset can be applied at any point in a stream. It discards the stored history.

Top module: `zero_pair_detector`

## Requirements
- R1: While `rst` is high, `hit` is 0, and after a clock edge with `rst` high the machine holds no bit history.
- R2: Once at least two bits have been accepted since reset, `hit` is 1 in a cycle exactly when `bit_in` and the two previously accepted bits contain two zeros and one one. In arrival order these are the patterns 001, 010 and 100.
- R3: `hit` is combinational in `bit_in`. A change of `bit_in` within a cycle changes `hit` in that same cycle, without waiting for a clock edge.
- R4: For the first two bits accepted after reset, `hit` is 0 whatever their values.
- R5: A reset in the middle of a stream discards all earlier bits. The window after reset contains only bits accepted after it.
- R6: The windows 000, 011, 101, 110 and 111 (in arrival order) give `hit` = 0.
- R7: A bit is accepted on each rising edge of `clk` while `rst` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; a bit is accepted on each rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Serial data bit for the current cycle |
| hit | output | 1 | High when the current three-bit window holds exactly two zeros |

## Verification
`hit` is due in the same cycle as the bit that completes the window. It needs no clock edge, because it is decoded from the stored state and the live input. The bench therefore drives `bit_in` and `rst` just after the falling edge and samples `hit` a short time later, before the next rising edge. It updates its own three-bit window model only once that edge has passed. One directed check changes `bit_in` twice within a single cycle and expects `hit` to follow both changes at once. Reset history is checked one edge after reset, on the first two bits of the new stream.

// File: rtl/zero_pair_pkg.sv
package zero_pair_pkg;

  localparam int STATE_W = 3;

  // Start-up states count the bits seen; steady states hold the last two bits.
  // The HIST names list the older bit first, then the newer one.
  typedef enum logic [STATE_W-1:0] {
    ZP_IDLE   = 3'd0,
    ZP_SEEN0  = 3'd1,
    ZP_SEEN1  = 3'd2,
    ZP_HIST11 = 3'd3,
    ZP_HIST01 = 3'd4,
    ZP_HIST10 = 3'd5,
    ZP_HIST00 = 3'd6
  } zp_state_e;

  function automatic logic zp_is_steady(zp_state_e s);
    return (s == ZP_HIST11) || (s == ZP_HIST01) ||
           (s == ZP_HIST10) || (s == ZP_HIST00);
  endfunction

  // Newest bit held by any state other than idle.
  function automatic logic zp_newest(zp_state_e s);
    return (s == ZP_SEEN1) || (s == ZP_HIST11) || (s == ZP_HIST01);
  endfunction

endpackage

// File: rtl/zpd_next_state.sv
module zpd_next_state
  import zero_pair_pkg::*;
(
  input  zp_state_e cur,
  input  logic      bit_in,
  output zp_state_e nxt
);

  logic newest;

  always_comb begin
    newest = zp_newest(cur);
    unique case (cur)
      ZP_IDLE:   nxt = bit_in ? ZP_SEEN1 : ZP_SEEN0;
      ZP_SEEN0,
      ZP_SEEN1,
      ZP_HIST11,
      ZP_HIST01,
      ZP_HIST10,
      ZP_HIST00: begin
        unique case ({newest, bit_in})
          2'b00:   nxt = ZP_HIST00;
          2'b01:   nxt = ZP_HIST01;
          2'b10:   nxt = ZP_HIST10;
          default: nxt = ZP_HIST11;
        endcase
      end
      default:   nxt = ZP_IDLE;
    endcase
  end

endmodule

// File: rtl/zpd_flag_decode.sv
module zpd_flag_decode
  import zero_pair_pkg::*;
(
  input  logic      rst,
  input  zp_state_e cur,
  input  logic      bit_in,
  output logic      hit
);

  always_comb begin
    hit = 1'b0;
    if (!rst) begin
      unique case (cur)
        ZP_HIST00:            hit = bit_in;
        ZP_HIST01, ZP_HIST10: hit = ~bit_in;
        default:              hit = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/zero_pair_detector.sv
module zero_pair_detector
  import zero_pair_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bit_in,
  output logic hit
);

  zp_state_e state_q;
  zp_state_e state_d;

  zpd_next_state u_next (
    .cur    (state_q),
    .bit_in (bit_in),
    .nxt    (state_d)
  );

  zpd_flag_decode u_flag (
    .rst    (rst),
    .cur    (state_q),
    .bit_in (bit_in),
    .hit    (hit)
  );

  always_ff @(posedge clk) begin
    if (rst) state_q <= ZP_IDLE;
    else     state_q <= state_d;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (state_q == ZP_IDLE)); // R1

  AST_NO_HIT_IN_RESET: assert property (@(posedge clk)
    rst |-> !hit); // R1

  AST_STARTUP_QUIET: assert property (@(posedge clk) disable iff (rst)
    !zp_is_steady(state_q) |-> !hit); // R4

  AST_LEAVE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (state_q == ZP_IDLE) |=> (state_q == ZP_SEEN0 || state_q == ZP_SEEN1)); // R7

  AST_SHIFT_NEWEST: assert property (@(posedge clk) disable iff (rst)
    (state_q != ZP_IDLE) |=> (zp_is_steady(state_q) && zp_newest(state_q) == $past(bit_in))); // R2

endmodule

// File: tb/zero_pair_detector_tb.sv
module zero_pair_detector_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int RAND_CYCLES = 3000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_in = 1'b0;
  logic hit;

  int n_checks = 0;
  int n_fail = 0;

  // Reference model: bits accepted since reset (saturating) and the last two bits.
  int  seen = 0;
  logic older = 1'b0;
  logic newer = 1'b0;

  zero_pair_detector dut_i (
    .clk    (clk),
    .rst    (rst),
    .bit_in (bit_in),
    .hit    (hit)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic ref_hit(logic r, int s, logic o, logic n, logic b);
    int zeros;
    if (r || s < 2) return 1'b0;
    zeros = (o ? 0 : 1) + (n ? 0 : 1) + (b ? 0 : 1);
    return zeros == 2;
  endfunction

  function automatic string req_tag(logic r, int s, logic e);
    if (r) return "R1";
    if (s < 2) return "R4";
    return e ? "R2" : "R6";
  endfunction

  task automatic check(string tag, logic exp);
    n_checks++;
    if (hit !== exp) begin
      n_fail++;
      $display("FAIL %s: hit=%b expected=%b at %0t", tag, hit, exp, $time);
    end
  endtask

  // Drive one cycle, check the live output, then let the edge accept the bit (R7).
  task automatic step(logic r, logic b);
    logic e;
    @(negedge clk);
    rst = r;
    bit_in = b;
    #1;
    e = ref_hit(r, seen, older, newer, b);
    check(req_tag(r, seen, e), e);
    @(posedge clk);
    if (r) begin
      seen = 0;
    end else begin
      older = newer;
      newer = b;
      if (seen < 2) seen++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: expired, expected finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // R1: reset state, with both input values
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    // R4: the first two bits after reset never report a hit
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    // R2: windows 001, 010, 100
    step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    // R6: 000, 001 again, then 011, 111, 110, 101
    step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    // R3: in history 00, hit follows bit_in within one cycle
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    @(negedge clk);
    bit_in = 1'b0;
    #1;
    check("R3", 1'b0);
    bit_in = 1'b1;
    #1;
    check("R3", 1'b1);
    bit_in = 1'b0;
    #1;
    check("R3", 1'b0);
    @(posedge clk);
    older = newer;
    newer = 1'b0;
    // R5: history 00 before reset, then a 1 after reset must not hit
    step(1'b0, 1'b0);
    step(1'b1, 1'b1);
    step(1'b0, 1'b1);
    check("R5", 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    // random stream with occasional mid-stream resets
    for (int i = 0; i < RAND_CYCLES; i++) begin
      logic r;
      r = ($urandom % 50) == 0;
      step(r, 1'($urandom % 2));
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule